// File: doc/BRIEF.md
# Dual-Clock FIFO with Per-Side Fill Levels

This block moves data words from a producer running on one clock to a consumer running on an unrelated clock. The producer offers a word with a valid strobe and sees a ready flag. The consumer sees the oldest stored word on its data output whenever its valid flag is high. It takes that word by raising its ready input. Each side also gets a fill count that it can use for flow control without any cross-domain logic of its own.

Each side keeps a binary pointer that is one bit wider than the storage address. The Gray form of each pointer is carried into the other domain through a chain of two flip-flops. Full, empty and both fill counts are worked out locally from the own pointer and the synchronized remote pointer. Because of this, each fill count trails activity on the far side by two edges of the local clock.

The requested capacity is rounded up to a power of two. A strict option instead refuses, at elaboration, any request that is not already a power of two. A reset of the write side blocks the read side from presenting data.

Top module: `cdc_queue`

## Requirements
- R1: The number of words the queue can hold is the smallest power of two that is at least REQ_DEPTH (a request of 3 holds exactly 4). With EXACT_DEPTH set, a REQ_DEPTH that is not a power of two stops elaboration with an error. A REQ_DEPTH below 2 is always rejected.
- R2: wr_ready is low exactly when the write-side count equals the capacity. A word offered while wr_ready is low is dropped and never appears at the read port.
- R3: rd_valid is high exactly when the read-side count is nonzero and wr_rst is low. While rd_valid is high, rd_data shows the oldest unread word, with no extra read latency.
- R4: wr_level equals the words accepted on the write side minus the words taken on the read side as they stood two wr_clk edges earlier. It never exceeds the capacity, and it never rises by more than one per wr_clk edge.
- R5: rd_level equals the words accepted on the write side as they stood two rd_clk edges earlier, minus the words taken on the read side. With both clocks tied together and one write per edge, rd_level after n writes is n-2, floored at 0.
- R6: Words come out in the order they went in, with none lost or repeated, both with shared clocks and with unrelated clock rates.
- R7: While wr_rst is high, rd_valid is low.
- R8: After reset, wr_ready is 1, rd_valid is 0, and both levels are 0.
- R9: Raising rd_ready while rd_valid is low takes nothing from the queue. rd_level stays 0, and later words still come out in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst | input | 1 | Write-domain reset, active high, asynchronous |
| wr_valid | input | 1 | Producer offers wr_data |
| wr_data | input | DATA_W | Word offered by the producer |
| wr_ready | output | 1 | Queue can accept a word this edge |
| wr_level | output | clog2(capacity)+1 | Fill count seen from the write side |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst | input | 1 | Read-domain reset, active high, asynchronous |
| rd_valid | output | 1 | rd_data holds a stored word |
| rd_ready | input | 1 | Consumer takes the word this edge |
| rd_data | output | DATA_W | Oldest stored word |
| rd_level | output | clog2(capacity)+1 | Fill count seen from the read side |

## Verification
The bench asks for a capacity of 3 and drives a fifth write into the queue. A design that did not round up to 4 would drop the fourth word or drain too few, and one that ignored wr_ready would later deliver the dropped word. With the clocks tied, each count is compared edge by edge against the two-edge lag. A synchronizer with one stage too many or too few shifts every expected level by one. Reads offered on an empty queue must leave the read count at zero; a design that moved its pointer anyway would skip or repeat words. A long run at unrelated clock rates, and a write-side reset held with words still stored, would expose misordered Gray conversion and data leaking out during reset.

// File: rtl/cdcq_pkg.sv
package cdcq_pkg;

    localparam int MAX_PTR_W = 32;

    function automatic logic [MAX_PTR_W-1:0] bin_to_gray(input logic [MAX_PTR_W-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [MAX_PTR_W-1:0] gray_to_bin(input logic [MAX_PTR_W-1:0] g);
        logic [MAX_PTR_W-1:0] b;
        for (int i = 0; i < MAX_PTR_W; i++) begin
            b[i] = ^(g >> i);
        end
        return b;
    endfunction

endpackage

// File: rtl/cdcq_sync.sv
module cdcq_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or posedge rst) begin
                if (rst) stage_q[s] <= '0;
                else     stage_q[s] <= stage_d[s];
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/cdcq_wr_side.sv
module cdcq_wr_side #(
    parameter int AW = 2,
    parameter int PW = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          valid,
    output logic          ready,
    input  logic [PW-1:0] rgray_sync,
    output logic [PW-1:0] wgray,
    output logic [AW-1:0] waddr,
    output logic          we,
    output logic [PW-1:0] level
);
    import cdcq_pkg::*;

    localparam logic [PW-1:0] FULL_MASK = PW'(3) << (PW - 2);

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
    } wptr_t;

    wptr_t ptr_d, ptr_q;
    logic  full;
    logic  push;
    logic [PW-1:0] rbin_seen;

    always_comb begin
        full      = (ptr_q.gray == (rgray_sync ^ FULL_MASK));
        push      = valid && !full;
        rbin_seen = PW'(gray_to_bin(MAX_PTR_W'(rgray_sync)));
        ptr_d     = ptr_q;
        if (push) begin
            ptr_d.bin  = ptr_q.bin + 1'b1;
            ptr_d.gray = PW'(bin_to_gray(MAX_PTR_W'(ptr_d.bin)));
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) ptr_q <= '0;
        else     ptr_q <= ptr_d;
    end

    assign ready = !full;
    assign we    = push;
    assign waddr = ptr_q.bin[AW-1:0];
    assign wgray = ptr_q.gray;
    assign level = ptr_q.bin - rbin_seen;
endmodule

// File: rtl/cdcq_rd_side.sv
module cdcq_rd_side #(
    parameter int AW = 2,
    parameter int PW = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hold,
    input  logic          ready,
    output logic          valid,
    input  logic [PW-1:0] wgray_sync,
    output logic [PW-1:0] rgray,
    output logic [AW-1:0] raddr,
    output logic [PW-1:0] level
);
    import cdcq_pkg::*;

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
    } rptr_t;

    rptr_t ptr_d, ptr_q;
    logic  empty;
    logic  pop;
    logic [PW-1:0] wbin_seen;

    always_comb begin
        empty     = (ptr_q.gray == wgray_sync);
        valid     = !empty && !hold;
        pop       = valid && ready;
        wbin_seen = PW'(gray_to_bin(MAX_PTR_W'(wgray_sync)));
        ptr_d     = ptr_q;
        if (pop) begin
            ptr_d.bin  = ptr_q.bin + 1'b1;
            ptr_d.gray = PW'(bin_to_gray(MAX_PTR_W'(ptr_d.bin)));
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) ptr_q <= '0;
        else     ptr_q <= ptr_d;
    end

    assign raddr = ptr_q.bin[AW-1:0];
    assign rgray = ptr_q.gray;
    assign level = wbin_seen - ptr_q.bin;
endmodule

// File: rtl/cdc_queue.sv
module cdc_queue #(
    parameter int DATA_W      = 8,
    parameter int REQ_DEPTH   = 8,
    parameter bit EXACT_DEPTH = 1'b0,
    parameter int SYNC_STAGES = 2
) (
    input  logic                               wr_clk,
    input  logic                               wr_rst,
    input  logic                               wr_valid,
    input  logic [DATA_W-1:0]                  wr_data,
    output logic                               wr_ready,
    output logic [$clog2(REQ_DEPTH):0]         wr_level,
    input  logic                               rd_clk,
    input  logic                               rd_rst,
    output logic                               rd_valid,
    input  logic                               rd_ready,
    output logic [DATA_W-1:0]                  rd_data,
    output logic [$clog2(REQ_DEPTH):0]         rd_level
);
    localparam int AW    = $clog2(REQ_DEPTH);
    localparam int DEPTH = 1 << AW;
    localparam int PW    = AW + 1;

    generate
        if (REQ_DEPTH < 2) begin : g_too_small
            $error("cdc_queue: requested capacity must be at least 2");
        end
        if (EXACT_DEPTH && (DEPTH != REQ_DEPTH)) begin : g_not_pow2
            $error("cdc_queue: exact capacity requested but it is not a power of two");
        end
    endgenerate

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PW-1:0]     wgray, rgray, wgray_in_rd, rgray_in_wr;
    logic [AW-1:0]     waddr, raddr;
    logic              we;

    cdcq_wr_side #(.AW(AW), .PW(PW)) u_wr (
        .clk        (wr_clk),
        .rst        (wr_rst),
        .valid      (wr_valid),
        .ready      (wr_ready),
        .rgray_sync (rgray_in_wr),
        .wgray      (wgray),
        .waddr      (waddr),
        .we         (we),
        .level      (wr_level)
    );

    cdcq_rd_side #(.AW(AW), .PW(PW)) u_rd (
        .clk        (rd_clk),
        .rst        (rd_rst),
        .hold       (wr_rst),
        .ready      (rd_ready),
        .valid      (rd_valid),
        .wgray_sync (wgray_in_rd),
        .rgray      (rgray),
        .raddr      (raddr),
        .level      (rd_level)
    );

    cdcq_sync #(.WIDTH(PW), .STAGES(SYNC_STAGES)) u_w2r (
        .clk  (rd_clk),
        .rst  (rd_rst),
        .din  (wgray),
        .dout (wgray_in_rd)
    );

    cdcq_sync #(.WIDTH(PW), .STAGES(SYNC_STAGES)) u_r2w (
        .clk  (wr_clk),
        .rst  (wr_rst),
        .din  (rgray),
        .dout (rgray_in_wr)
    );

    always_ff @(posedge wr_clk) begin
        if (we) mem[waddr] <= wr_data;
    end

    assign rd_data = mem[raddr];
endmodule

// File: rtl/cdc_queue_chk.sv
module cdc_queue_chk #(
    parameter int DEPTH = 4,
    parameter int PW    = 3
) (
    input logic          wr_clk,
    input logic          wr_rst,
    input logic          rd_clk,
    input logic          rd_rst,
    input logic          wr_ready,
    input logic          rd_valid,
    input logic [PW-1:0] wr_level,
    input logic [PW-1:0] rd_level
);
    // R4: write-side count bounded by the capacity
    p_wlevel_cap_r4: assert property (@(posedge wr_clk) disable iff (wr_rst || rd_rst)
        wr_level <= PW'(DEPTH));

    // R4: write-side count grows by at most one per edge
    p_wlevel_step_r4: assert property (@(posedge wr_clk) disable iff (wr_rst || rd_rst)
        {1'b0, wr_level} <= {1'b0, $past(wr_level)} + 1'b1);

    // R2: a full count means no acceptance
    p_full_stall_r2: assert property (@(posedge wr_clk) disable iff (wr_rst || rd_rst)
        (wr_level == PW'(DEPTH)) |-> !wr_ready);

    // R5: read-side count bounded by the capacity
    p_rlevel_cap_r5: assert property (@(posedge rd_clk) disable iff (wr_rst || rd_rst)
        rd_level <= PW'(DEPTH));

    // R3: nothing presented when the read-side count is zero
    p_empty_quiet_r3: assert property (@(posedge rd_clk) disable iff (wr_rst || rd_rst)
        (rd_level == '0) |-> !rd_valid);

    // R3: something presented when the read-side count is nonzero
    p_data_shown_r3: assert property (@(posedge rd_clk) disable iff (wr_rst || rd_rst)
        (rd_level != '0) |-> rd_valid);

    // R7: write-side reset silences the read port
    always_comb begin
        if (wr_rst) begin
            p_wrst_blocks_r7: assert (!rd_valid);
        end
    end
endmodule

bind cdc_queue cdc_queue_chk #(.DEPTH(DEPTH), .PW(PW)) u_chk (.*);

// File: tb/test_cdc_queue.sv
`timescale 1ns/1ps
module test_cdc_queue;
    localparam int DW  = 8;
    localparam int REQ = 3;
    localparam int LW  = $clog2(REQ) + 1;

    logic          wr_clk = 1'b0, rd_clk = 1'b0, shared = 1'b1;
    logic          wr_rst = 1'b1, rd_rst = 1'b1;
    logic          wr_valid = 1'b0, rd_ready = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          wr_ready, rd_valid;
    logic [DW-1:0] rd_data;
    logic [LW-1:0] wr_level, rd_level;

    int n_chk = 0, n_bad = 0;
    bit finished = 1'b0;

    cdc_queue #(.DATA_W(DW), .REQ_DEPTH(REQ), .EXACT_DEPTH(1'b0)) i_cdc_queue (
        .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_ready(wr_ready), .wr_level(wr_level),
        .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_valid(rd_valid), .rd_ready(rd_ready),
        .rd_data(rd_data), .rd_level(rd_level)
    );

    // 250 MHz write clock; read clock follows it or runs at 7 ns on its own
    always begin
        #2;
        wr_clk = ~wr_clk;
        if (shared) rd_clk = wr_clk;
    end
    always begin
        #3.5;
        if (!shared) rd_clk = ~rd_clk;
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    typedef struct packed {
        logic          wv;
        logic [DW-1:0] d;
        logic          rr;
        logic          e_wrdy;
        logic          e_rvld;
        logic [DW-1:0] e_data;
        logic [LW-1:0] e_wlev;
        logic [LW-1:0] e_rlev;
    } vec_t;

    // Shared-clock walk; capacity 4 after rounding (R1), two-edge lag (R4, R5)
    localparam vec_t TBL [12] = '{
        '{1'b1, 8'h11, 1'b0, 1'b1, 1'b0, 8'h00, 3'd0, 3'd0},
        '{1'b1, 8'h22, 1'b0, 1'b1, 1'b0, 8'h00, 3'd1, 3'd0},
        '{1'b1, 8'h33, 1'b0, 1'b1, 1'b0, 8'h00, 3'd2, 3'd0},
        '{1'b1, 8'h44, 1'b1, 1'b1, 1'b1, 8'h11, 3'd3, 3'd1},
        '{1'b1, 8'h55, 1'b0, 1'b0, 1'b1, 8'h22, 3'd4, 3'd1},
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'h22, 3'd4, 3'd2},
        '{1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 8'h22, 3'd3, 3'd3},
        '{1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 8'h33, 3'd3, 3'd2},
        '{1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 8'h44, 3'd3, 3'd1},
        '{1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 8'h00, 3'd2, 3'd0},
        '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00, 3'd1, 3'd0},
        '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00, 3'd0, 3'd0}
    };

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not complete actual=hung expected=done");
            report();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge wr_clk);
        // R8: reset state
        chk("R8 wr_ready", int'(wr_ready), 1);
        chk("R8 rd_valid", int'(rd_valid), 0);
        chk("R8 wr_level", int'(wr_level), 0);
        chk("R8 rd_level", int'(rd_level), 0);
        wr_rst = 1'b0;
        rd_rst = 1'b0;

        for (int s = 0; s < 12; s++) begin
            @(negedge wr_clk);
            wr_valid = TBL[s].wv;
            wr_data  = TBL[s].d;
            rd_ready = TBL[s].rr;
            #1;
            chk($sformatf("R1 R2 wr_ready step %0d", s), int'(wr_ready), int'(TBL[s].e_wrdy));
            chk($sformatf("R3 R9 rd_valid step %0d", s), int'(rd_valid), int'(TBL[s].e_rvld));
            chk($sformatf("R4 wr_level step %0d", s), int'(wr_level), int'(TBL[s].e_wlev));
            chk($sformatf("R5 R9 rd_level step %0d", s), int'(rd_level), int'(TBL[s].e_rlev));
            if (TBL[s].e_rvld)
                chk($sformatf("R3 R6 rd_data step %0d", s), int'(rd_data), int'(TBL[s].e_data));
        end
        @(negedge wr_clk);
        wr_valid = 1'b0;
        rd_ready = 1'b0;

        // R9: after the ignored empty reads, new words still come out first
        wr_valid = 1'b1;
        wr_data  = 8'h66;
        @(negedge wr_clk);
        wr_data  = 8'h77;
        @(negedge wr_clk);
        wr_valid = 1'b0;
        repeat (4) @(negedge wr_clk);
        #1;
        chk("R9 rd_data after empty pops", int'(rd_data), 'h66);
        chk("R3 rd_valid before write reset", int'(rd_valid), 1);

        // R7: write-side reset with words stored
        wr_rst = 1'b1;
        #0.5;
        chk("R7 rd_valid during write reset", int'(rd_valid), 0);
        @(negedge wr_clk);
        chk("R7 rd_valid held low", int'(rd_valid), 0);
        rd_rst = 1'b1;
        shared = 1'b0;
        repeat (3) @(negedge wr_clk);
        wr_rst = 1'b0;
        rd_rst = 1'b0;
        #1;
        chk("R8 wr_level after second reset", int'(wr_level), 0);
        chk("R8 rd_valid after second reset", int'(rd_valid), 0);

        // R2 R4 R5: six offers into a capacity of four, unrelated clocks
        for (int k = 0; k < 6; k++) begin
            @(negedge wr_clk);
            wr_valid = 1'b1;
            wr_data  = 8'hA0 + 8'(k);
        end
        @(negedge wr_clk);
        wr_valid = 1'b0;
        repeat (10) @(negedge wr_clk);
        chk("R2 wr_ready when full", int'(wr_ready), 0);
        chk("R4 wr_level saturates", int'(wr_level), 4);
        chk("R5 rd_level settles", int'(rd_level), 4);

        for (int k = 0; k < 4; k++) begin
            @(negedge rd_clk);
            rd_ready = 1'b1;
            chk($sformatf("R6 R2 drain word %0d", k), int'(rd_data), 'hA0 + k);
        end
        @(negedge rd_clk);
        rd_ready = 1'b0;
        chk("R2 overflow words dropped", int'(rd_valid), 0);

        // R6: concurrent streaming at unrelated rates
        fork
            begin
                int sent = 0;
                while (sent < 24) begin
                    @(negedge wr_clk);
                    wr_valid = 1'b1;
                    wr_data  = 8'h40 + 8'(sent);
                    if (wr_ready) sent++;
                end
                @(negedge wr_clk);
                wr_valid = 1'b0;
            end
            begin
                int got = 0;
                int cyc = 0;
                while (got < 24) begin
                    logic take;
                    @(negedge rd_clk);
                    take = (cyc % 3) != 2;
                    rd_ready = take;
                    if (rd_valid && take) begin
                        chk($sformatf("R6 stream word %0d", got), int'(rd_data), 'h40 + got);
                        got++;
                    end
                    cyc++;
                end
                @(negedge rd_clk);
                rd_ready = 1'b0;
            end
        join
        repeat (8) @(negedge rd_clk);
        chk("R5 rd_level drained", int'(rd_level), 0);
        chk("R4 wr_level drained", int'(wr_level), 0);
        chk("R6 nothing left over", int'(rd_valid), 0);

        finished = 1'b1;
        report();
        $finish;
    end
endmodule